// File: doc/BRIEF.md
# Sector Signature Auto-Compare Controller

This block checks memory contents sector by sector. An external compressor folds each sector into a 64-bit signature. When the compressor finishes a sector, it strobes `sector_done` for one cycle and presents the signature on `sig_in`. In auto mode the controller keeps the expected checksum for the current sector in a 64-bit register, and a DMA engine refills that register between sectors. At each sector end the controller compares the signature with the stored value. A mismatch raises a failure interrupt.

A freshness flag records whether the expected value has been reloaded since the last compare. If a sector ends while the flag is clear, the stored value is stale. The block then raises an underrun interrupt and does not compare.

The two software-driven modes work differently. In semi-software mode the controller only signals that compression is complete, and software compares the values itself. In full-software mode the controller stays silent. Neither of these modes touches the expected-value register.

Top module: `sig_autocmp`

## Requirements
- R1: After reset, `exp_q` is zero, `fresh` is 0, and `dma_req`, `irq_fail`, `irq_underrun` and `irq_cc` are all 0.
- R2: `mode` selects the operating mode: 2'b10 is auto, 2'b01 is semi-software, and 2'b00 or 2'b11 is full-software.
- R3: When `mode` changes from a non-auto value to auto, `dma_req` pulses high for exactly one cycle, in the cycle after the change is sampled. Entering auto mode also clears `fresh`, unless a high-half write happens in the same cycle.
- R4: In auto mode, every `sector_done` strobe produces a one-cycle `dma_req` pulse in the following cycle. This holds whether the sector ended in a compare or in an underrun.
- R5: In auto mode, a `sector_done` strobe with `fresh` set compares all 64 bits of `sig_in` with `exp_q`. If any bit differs and `en_fail` is 1, `irq_fail` pulses one cycle later. The compare clears `fresh`.
- R6: In auto mode, a `sector_done` strobe with `fresh` clear pulses `irq_underrun` one cycle later if `en_underrun` is 1. In this case `irq_fail` stays 0 whatever the value of `sig_in`.
- R7: In semi-software mode, a `sector_done` strobe pulses `irq_cc` one cycle later if `en_cc` is 1. No compare, fail, underrun or `dma_req` results.
- R8: In full-software mode, a `sector_done` strobe produces no interrupt and no `dma_req`.
- R9: In auto mode, a write updates each byte k of `exp_q` (bits 8k+7 to 8k) for which `wr_be[k]` is set. This allows 8-, 16-, 32- and 64-bit writes. The low half is bytes 0 to 3 and the high half is bytes 4 to 7.
- R10: A write sets `fresh` only when at least one high-half byte enable (`wr_be[7:4]`) is set. A write to the low half alone leaves `fresh` unchanged.
- R11: Outside auto mode, writes are ignored, and `exp_q` and `fresh` keep their values.
- R12: If a high-half write arrives in the same cycle as an auto-mode `sector_done`, the compare uses the value stored before the write, and `fresh` ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Operating mode (10 auto, 01 semi-software, 00/11 full-software) |
| wr_en | input | 1 | Write strobe for the expected-value register |
| wr_be | input | 8 | Byte enables for the write |
| wr_data | input | 64 | Write data, with byte k on bits 8k+7 to 8k |
| sector_done | input | 1 | One-cycle end-of-sector strobe |
| sig_in | input | 64 | Sector signature, valid while `sector_done` is high |
| en_fail | input | 1 | Enable for the failure interrupt |
| en_underrun | input | 1 | Enable for the underrun interrupt |
| en_cc | input | 1 | Enable for the compression-complete interrupt |
| exp_q | output | 64 | Current expected value |
| fresh | output | 1 | Expected value reloaded since the last compare |
| dma_req | output | 1 | One-cycle reload request |
| irq_fail | output | 1 | One-cycle signature-mismatch interrupt |
| irq_underrun | output | 1 | One-cycle stale-value interrupt |
| irq_cc | output | 1 | One-cycle compression-complete interrupt (semi-software) |

## Verification
The bench writes only the low half and then ends a sector. A design that set `fresh` on any write would compare against a half-loaded value and miss the underrun. It ends a sector with no reload and a wrong signature. A design that still compared would raise `irq_fail` instead of `irq_underrun`. It issues a high-half write in the same cycle as `sector_done`. A design with the wrong priority would compare against the new value, or would lose the fresh flag for the next sector. It also writes in the software modes and re-enters auto mode. A design that updated the register outside auto mode, or that did not request a reload on entry, would show a changed `exp_q` or a missing `dma_req` pulse.

// File: rtl/sig_autocmp.sv
module sig_autocmp #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          wr_en,
  input  logic [DW/8-1:0] wr_be,
  input  logic [DW-1:0] wr_data,
  input  logic          sector_done,
  input  logic [DW-1:0] sig_in,
  input  logic          en_fail,
  input  logic          en_underrun,
  input  logic          en_cc,
  output logic [DW-1:0] exp_q,
  output logic          fresh,
  output logic          dma_req,
  output logic          irq_fail,
  output logic          irq_underrun,
  output logic          irq_cc
);
  localparam int NB = DW / 8;
  localparam int HB = NB / 2;
  localparam logic [1:0] M_AUTO = 2'b10;
  localparam logic [1:0] M_SEMI = 2'b01;

  logic was_auto;
  wire  is_auto  = (mode == M_AUTO);
  wire  is_semi  = (mode == M_SEMI);
  wire  enter    = is_auto && !was_auto;
  wire  wr_ok    = wr_en && is_auto;
  wire  wr_hi    = wr_ok && (|wr_be[NB-1:HB]);
  wire  end_auto = sector_done && is_auto;

  logic [DW-1:0] exp_d;
  always_comb begin
    exp_d = exp_q;
    for (int k = 0; k < NB; k++)
      if (wr_ok && wr_be[k]) exp_d[8*k +: 8] = wr_data[8*k +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_q        <= '0;
      fresh        <= 1'b0;
      was_auto     <= 1'b0;
      dma_req      <= 1'b0;
      irq_fail     <= 1'b0;
      irq_underrun <= 1'b0;
      irq_cc       <= 1'b0;
    end else begin
      was_auto     <= is_auto;
      exp_q        <= exp_d;
      if (wr_hi)                 fresh <= 1'b1;
      else if (end_auto || enter) fresh <= 1'b0;
      dma_req      <= enter || end_auto;
      irq_fail     <= end_auto && fresh && en_fail && (sig_in != exp_q);
      irq_underrun <= end_auto && !fresh && en_underrun;
      irq_cc       <= sector_done && is_semi && en_cc;
    end
  end

  // R6: a stale value never yields a fail
  a_r6_no_fail_when_stale: assert property (@(posedge clk) disable iff (!rst_n)
    (sector_done && !fresh) |=> !irq_fail);
  // R5: a compare consumes the fresh flag
  a_r5_compare_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (sector_done && mode == M_AUTO && !(wr_en && |wr_be[NB-1:HB])) |=> !fresh);
  // R11: software modes leave the expected value alone
  a_r11_hold_outside_auto: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_AUTO) |=> ($stable(exp_q) && $stable(fresh)));
  // R7: interrupts are mutually exclusive
  a_r7_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_fail, irq_underrun, irq_cc}));
  // R8: no reload request without auto mode
  a_r8_no_dma_soft: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_AUTO) |=> !dma_req);
  // R4: a sector end in auto mode requests a reload
  a_r4_dma_after_sector: assert property (@(posedge clk) disable iff (!rst_n)
    (sector_done && mode == M_AUTO) |=> dma_req);
endmodule

// File: tb/sig_autocmp_tb.sv
module sig_autocmp_tb;
  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 2'b00;
  logic wr_en = 0;
  logic [7:0] wr_be = 0;
  logic [63:0] wr_data = 0, sig_in = 0;
  logic sector_done = 0, en_fail = 1, en_underrun = 1, en_cc = 1;
  logic [63:0] exp_q;
  logic fresh, dma_req, irq_fail, irq_underrun, irq_cc;
  int n_cmp = 0, n_bad = 0;
  logic [63:0] model;

  always #10 clk = ~clk;

  sig_autocmp u_dut (.clk, .rst_n, .mode, .wr_en, .wr_be, .wr_data, .sector_done,
    .sig_in, .en_fail, .en_underrun, .en_cc, .exp_q, .fresh, .dma_req,
    .irq_fail, .irq_underrun, .irq_cc);

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic pulses(input string tag, input logic d, input logic f, input logic u, input logic c);
    chk({tag, " dma"}, dma_req, d);
    chk({tag, " fail"}, irq_fail, f);
    chk({tag, " underrun"}, irq_underrun, u);
    chk({tag, " cc"}, irq_cc, c);
  endtask

  task automatic wr(input logic [7:0] be, input logic [63:0] d);
    wr_en = 1; wr_be = be; wr_data = d; tick(); wr_en = 0; wr_be = 0;
  endtask

  task automatic done(input logic [63:0] s);
    sector_done = 1; sig_in = s; tick(); sector_done = 0;
  endtask

  task automatic t_reset();
    pulses("R1", 0, 0, 0, 0);
    chk("R1 exp", exp_q, 0);
    chk("R1 fresh", fresh, 0);
  endtask

  task automatic t_enter_auto();
    mode = 2'b10; tick();
    chk("R3 entry dma", dma_req, 1);
    tick();
    chk("R3 single pulse", dma_req, 0);
  endtask

  task automatic t_low_then_high();
    wr(8'h0F, 64'h0000_0000_1234_5678);
    chk("R10 low only", fresh, 0);
    chk("R9 low half", exp_q, 64'h0000_0000_1234_5678);
    wr(8'hF0, 64'h9ABC_DEF0_0000_0000);
    chk("R10 high sets", fresh, 1);
    model = 64'h9ABC_DEF0_1234_5678;
    chk("R9 full value", exp_q, model);
  endtask

  task automatic t_match();
    done(model);
    pulses("R5 match", 1, 0, 0, 0);
    chk("R5 fresh cleared", fresh, 0);
    tick();
    chk("R4 dma single", dma_req, 0);
  endtask

  task automatic t_mismatch();
    wr(8'hFF, 64'hCAFE_F00D_0BAD_BEEF);
    model = 64'hCAFE_F00D_0BAD_BEEF;
    done(model ^ 64'h8000_0000_0000_0000);
    pulses("R5 mismatch", 1, 1, 0, 0);
    tick();
    chk("R5 fail single", irq_fail, 0);
  endtask

  task automatic t_underrun();
    done(64'h1);
    pulses("R6 underrun", 1, 0, 1, 0);
    wr(8'h0F, 64'h0000_0000_FFFF_FFFF);
    model[31:0] = 32'hFFFF_FFFF;
    done(64'h0);
    pulses("R6 R10 low-only underrun", 1, 0, 1, 0);
  endtask

  task automatic t_bytes();
    wr(8'h01, 64'h0000_0000_0000_00A5);
    model[7:0] = 8'hA5;
    chk("R9 byte", exp_q, model);
    wr(8'h30, 64'h0000_7E7E_0000_0000);
    model[47:32] = 16'h7E7E;
    chk("R9 halfword", exp_q, model);
    chk("R10 halfword fresh", fresh, 1);
  endtask

  task automatic t_enables();
    en_fail = 0;
    done(~model);
    pulses("R5 fail disabled", 1, 0, 0, 0);
    en_underrun = 0;
    done(~model);
    pulses("R6 underrun disabled", 1, 0, 0, 0);
    en_fail = 1; en_underrun = 1;
  endtask

  task automatic t_same_cycle();
    wr(8'hFF, 64'h1111_2222_3333_4444);
    wr_en = 1; wr_be = 8'hF0; wr_data = 64'h5555_6666_0000_0000;
    sector_done = 1; sig_in = 64'h1111_2222_3333_4444;
    tick();
    wr_en = 0; wr_be = 0; sector_done = 0;
    pulses("R12 old value compared", 1, 0, 0, 0);
    chk("R12 fresh kept", fresh, 1);
    model = 64'h5555_6666_3333_4444;
    chk("R12 new value", exp_q, model);
  endtask

  task automatic t_semi();
    mode = 2'b01; tick();
    done(64'h0);
    pulses("R7 semi", 0, 0, 0, 1);
    wr(8'hFF, 64'hDEAD_DEAD_DEAD_DEAD);
    chk("R11 semi write ignored", exp_q, model);
    chk("R11 semi fresh kept", fresh, 1);
    en_cc = 0;
    done(64'h0);
    pulses("R7 cc disabled", 0, 0, 0, 0);
    en_cc = 1;
  endtask

  task automatic t_full();
    mode = 2'b00; tick();
    done(64'h0);
    pulses("R8 full", 0, 0, 0, 0);
    wr(8'hFF, 64'h0);
    chk("R11 full write ignored", exp_q, model);
    mode = 2'b11; tick();
    done(64'h0);
    pulses("R2 code 11 is full", 0, 0, 0, 0);
  endtask

  task automatic t_reenter();
    mode = 2'b10; tick();
    chk("R3 re-entry dma", dma_req, 1);
    chk("R3 re-entry clears fresh", fresh, 0);
    tick();
    done(model);
    pulses("R3 R6 stale after entry", 1, 0, 1, 0);
  endtask

  initial begin
    #200000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tick(); tick();
    t_reset();
    rst_n = 1; tick();
    t_reset();
    t_enter_auto();
    t_low_then_high();
    t_match();
    t_mismatch();
    t_underrun();
    t_bytes();
    t_enables();
    t_same_cycle();
    t_semi();
    t_full();
    t_reenter();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule